// File: doc/BRIEF.md
# Boot Remap and Abort Decoder

This block sits between a processor's address bus and the memory system of a small controller. For each access it sorts the address into one of three regions: on-chip memory, on-chip peripherals, or the external bus. When the address falls in the external bus range, the block also works out which chip select owns it. Chip select bank `i` covers one naturally aligned window of `2**BANK_LOG2` bytes, starting at `CS_BASE + i * 2**BANK_LOG2`.

Out of reset the block is in boot mapping. In this mapping the lowest bank of the address space is an alias of the chip-select-0 device, so the processor can fetch its first instructions from external boot storage. In boot mapping only chip select 0 can be reached. Software then writes a one to the remap bit of the control register. After that, the lowest bank becomes on-chip memory and chip selects 1 and up become reachable. Only reset returns the block to boot mapping.

Any access to an external bus address that no chip select owns produces an abort pulse in the same cycle. It is a data abort for a load or store, and a prefetch abort for an instruction fetch. Accesses to on-chip memory and to on-chip peripherals never abort.

Top module: `remap_abort_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the remap state is cleared. After that edge, `ctl_rdata` reads all zeros.
- R2: A clock edge with `ctl_wr` high and `ctl_wdata` high sets the remap state. From the next cycle, bit 0 of `ctl_rdata` reads 1 and all other bits read 0.
- R3: A write with `ctl_wdata` low leaves the remap state unchanged. Once set, the remap state stays set until reset.
- R4: In the low space (addresses below 0x0040_0000), the behaviour depends on the remap state:
  - Before remap, an address whose bits [31:20] are zero selects the external region with `cs_hit`=1 and `cs_idx`=0.
  - After remap, every low-space address selects on-chip memory (`sel_mem`).
- R5: An address whose bits [31:20] equal 4+i (i = 0..7) selects the external region with `cs_hit`=1 and `cs_idx`=i. For i ≥ 1 this holds only after remap. Before remap, such an address is an undefined external address.
- R6: With `bus_req` high, an address in [0x0040_0000, 0xFFC0_0000) that no chip select owns selects the external region with `cs_hit`=0. In that same cycle, `prefetch_abort` is raised if `bus_fetch` is high, and `data_abort` is raised otherwise.
- R7: Addresses at or above 0xFFC0_0000 select peripherals (`sel_periph`). Neither peripheral accesses nor on-chip memory accesses raise any abort.
- R8: With `bus_req` low, all selects, `cs_hit`, `cs_idx` and both abort outputs are zero. With `bus_req` high, exactly one of `sel_mem`, `sel_periph` and `sel_ext` is high.
- R9: The region edges are exact:
  - 0x003F_FFFF is low space.
  - 0x0040_0000 and 0xFFBF_FFFF are external.
  - 0xFFC0_0000 is peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, high for each cycle of an access |
| bus_fetch | input | 1 | High when the access is an instruction fetch |
| bus_addr | input | ADDR_W | Byte address of the access |
| ctl_wr | input | 1 | Write strobe for the remap control register |
| ctl_wdata | input | 1 | Value written to the remap bit (bit 0) |
| ctl_rdata | output | REG_W | Remap control register read value, state in bit 0 |
| sel_mem | output | 1 | Access targets on-chip memory |
| sel_periph | output | 1 | Access targets on-chip peripherals |
| sel_ext | output | 1 | Access targets the external bus |
| cs_hit | output | 1 | External access owned by a chip select |
| cs_idx | output | $clog2(NUM_CS) | Index of the owning chip select, zero when none |
| data_abort | output | 1 | Load/store hit an undefined external address |
| prefetch_abort | output | 1 | Fetch hit an undefined external address |

## Verification
The bench sweeps every 1 MB block of the address space at the first byte and the last byte of the block. It does this for both fetch and load/store, once in boot mapping and once after remap. An off-by-one in a region compare would misplace 0x003F_FFFF, 0x0040_0000 or 0xFFC0_0000 and show up as a wrong select or a spurious abort. A design that left chip selects 1–7 reachable during boot would miss the aborts expected at blocks 5–11. A design that did not drop the boot alias after remap would keep sending address 0 to chip select 0. A remap bit that cleared on a zero write, or that survived reset, is caught by register reads taken around those events.

// File: rtl/rad_pkg.sv
// Shared types for the remap/abort decoder.
package rad_pkg;
    // Region classes an address can fall in.
    typedef enum logic [1:0] {
        RGN_MEM    = 2'd0,
        RGN_PERIPH = 2'd1,
        RGN_EXT    = 2'd2
    } rgn_e;
endpackage

// File: rtl/rad_remap_latch.sv
// One-way remap state: set by a control write with data one,
// cleared only by synchronous active-low reset.
// Assumes the control port is already qualified as addressing this register.
module rad_remap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic remap_o
);
    logic remap_q;

    // Latch the remap request; zero writes leave the state alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_q <= 1'b0;
        else if (wr_i && wdata_i)
            remap_q <= 1'b1;
    end

    assign remap_o = remap_q;
endmodule

// File: rtl/rad_map_decode.sv
// Address map decode: classifies an address into memory, peripheral or
// external region and resolves the owning chip select.
// Assumes every chip-select bank lies inside [EXT_LO, PERIPH_BASE).
module rad_map_decode
    import rad_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                NUM_CS      = 8,
    parameter int                BANK_LOG2   = 20,
    parameter logic [ADDR_W-1:0] CS_BASE     = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] EXT_LO      = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hFFC0_0000,
    localparam int               CS_W        = $clog2(NUM_CS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              remap_i,
    output rgn_e              rgn_o,
    output logic              hit_o,
    output logic [CS_W-1:0]   idx_o
);
    localparam int BLK_W    = ADDR_W - BANK_LOG2;
    localparam int BASE_BLK = int'(CS_BASE >> BANK_LOG2);

    logic [BLK_W-1:0]  blk;
    logic [NUM_CS-1:0] bank_hit;
    logic              in_periph;
    logic              in_ext;
    logic              boot_alias;
    logic              any_hit;
    logic [CS_W-1:0]   enc_idx;

    assign blk = addr_i[ADDR_W-1:BANK_LOG2];

    // One comparator per bank; banks above 0 are gated until remap.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
        if (i == 0) begin : g_boot_bank
            assign bank_hit[i] = (blk == BLK_W'(BASE_BLK));
        end else begin : g_late_bank
            assign bank_hit[i] = (blk == BLK_W'(BASE_BLK + i)) && remap_i;
        end
    end

    // Encode the (at most one) matching bank into an index.
    always_comb begin
        any_hit = 1'b0;
        enc_idx = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (bank_hit[i]) begin
                any_hit = 1'b1;
                enc_idx = CS_W'(i);
            end
        end
    end

    assign in_periph  = (addr_i >= PERIPH_BASE);
    assign in_ext     = !in_periph && (addr_i >= EXT_LO);
    assign boot_alias = !remap_i && (blk == '0);

    // Region selection, with the boot alias steering the lowest bank outward.
    always_comb begin
        rgn_o = RGN_MEM;
        hit_o = 1'b0;
        idx_o = '0;
        if (in_periph) begin
            rgn_o = RGN_PERIPH;
        end else if (in_ext) begin
            rgn_o = RGN_EXT;
            hit_o = any_hit;
            idx_o = any_hit ? enc_idx : '0;
        end else if (boot_alias) begin
            rgn_o = RGN_EXT;
            hit_o = 1'b1;
        end
    end
endmodule

// File: rtl/rad_abort_gen.sv
// Abort generation: flags a strobed access to an external address that no
// chip select owns, split by fetch versus load/store. Purely combinational,
// so the pulse covers exactly the strobed cycle.
module rad_abort_gen
    import rad_pkg::*;
(
    input  logic req_i,
    input  logic fetch_i,
    input  rgn_e rgn_i,
    input  logic hit_i,
    output logic dabt_o,
    output logic pabt_o
);
    logic undefined_ext;

    // Only external space can be undefined; internal space never aborts.
    assign undefined_ext = req_i && (rgn_i == RGN_EXT) && !hit_i;

    // Route the abort by access kind.
    assign dabt_o = undefined_ext && !fetch_i;
    assign pabt_o = undefined_ext && fetch_i;
endmodule

// File: rtl/remap_abort_decoder.sv
// Top: boot remap state, region/chip-select decode and abort pulses.
// Outputs are combinational from the bus inputs and the remap state and are
// valid only in cycles where bus_req is high.
module remap_abort_decoder
    import rad_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                NUM_CS      = 8,
    parameter int                BANK_LOG2   = 20,
    parameter logic [ADDR_W-1:0] CS_BASE     = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] EXT_LO      = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hFFC0_0000,
    parameter int                REG_W       = 32,
    localparam int               CS_W        = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctl_wr,
    input  logic              ctl_wdata,
    output logic [REG_W-1:0]  ctl_rdata,
    output logic              sel_mem,
    output logic              sel_periph,
    output logic              sel_ext,
    output logic              cs_hit,
    output logic [CS_W-1:0]   cs_idx,
    output logic              data_abort,
    output logic              prefetch_abort
);
    logic            remap;
    rgn_e            rgn;
    logic            hit;
    logic [CS_W-1:0] idx;

    rad_remap_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .remap_o (remap)
    );

    rad_map_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_CS      (NUM_CS),
        .BANK_LOG2   (BANK_LOG2),
        .CS_BASE     (CS_BASE),
        .EXT_LO      (EXT_LO),
        .PERIPH_BASE (PERIPH_BASE)
    ) u_decode (
        .addr_i  (bus_addr),
        .remap_i (remap),
        .rgn_o   (rgn),
        .hit_o   (hit),
        .idx_o   (idx)
    );

    rad_abort_gen u_abort (
        .req_i   (bus_req),
        .fetch_i (bus_fetch),
        .rgn_i   (rgn),
        .hit_i   (hit),
        .dabt_o  (data_abort),
        .pabt_o  (prefetch_abort)
    );

    // Qualify decode results with the access strobe.
    assign sel_mem    = bus_req && (rgn == RGN_MEM);
    assign sel_periph = bus_req && (rgn == RGN_PERIPH);
    assign sel_ext    = bus_req && (rgn == RGN_EXT);
    assign cs_hit     = bus_req && hit;
    assign cs_idx     = bus_req ? idx : '0;

    // Register read value: remap state in bit 0.
    assign ctl_rdata  = REG_W'(remap);
endmodule

// File: rtl/rad_checker.sv
// Property checker for remap_abort_decoder, attached by bind.
module rad_checker #(
    parameter int CS_W  = 3,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_fetch,
    input logic             ctl_wr,
    input logic             ctl_wdata,
    input logic [REG_W-1:0] ctl_rdata,
    input logic             sel_mem,
    input logic             sel_periph,
    input logic             sel_ext,
    input logic             cs_hit,
    input logic [CS_W-1:0]  cs_idx,
    input logic             data_abort,
    input logic             prefetch_abort
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_rdata == '0));

    // R2
    remap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata) |=> ctl_rdata[0]);

    // R3
    remap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[0] |=> ctl_rdata[0]);

    // R3
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rdata[0] && !(ctl_wr && ctl_wdata)) |=> !ctl_rdata[0]);

    // R5
    late_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hit && cs_idx != '0) |-> ctl_rdata[0]);

    // R6
    abort_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_abort |-> bus_fetch) and (data_abort |-> !bus_fetch));

    // R6
    abort_where_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_abort || prefetch_abort) |-> (sel_ext && !cs_hit));

    // R7
    internal_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mem || sel_periph) |-> !(data_abort || prefetch_abort));

    // R8
    select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $onehot({sel_mem, sel_periph, sel_ext}));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> !(sel_mem || sel_periph || sel_ext || cs_hit
                       || data_abort || prefetch_abort));
endmodule

bind remap_abort_decoder rad_checker #(
    .CS_W  (CS_W),
    .REG_W (REG_W)
) u_rad_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_fetch      (bus_fetch),
    .ctl_wr         (ctl_wr),
    .ctl_wdata      (ctl_wdata),
    .ctl_rdata      (ctl_rdata),
    .sel_mem        (sel_mem),
    .sel_periph     (sel_periph),
    .sel_ext        (sel_ext),
    .cs_hit         (cs_hit),
    .cs_idx         (cs_idx),
    .data_abort     (data_abort),
    .prefetch_abort (prefetch_abort)
);

// File: tb/sim_remap_abort_decoder.sv
module sim_remap_abort_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_fetch = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        ctl_wr = 1'b0;
    logic        ctl_wdata = 1'b0;
    logic [31:0] ctl_rdata;
    logic        sel_mem, sel_periph, sel_ext, cs_hit;
    logic [2:0]  cs_idx;
    logic        data_abort, prefetch_abort;

    int checks = 0;
    int fails  = 0;
    logic exp_remap = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    remap_abort_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_fetch(bus_fetch),
        .bus_addr(bus_addr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sel_mem(sel_mem), .sel_periph(sel_periph),
        .sel_ext(sel_ext), .cs_hit(cs_hit), .cs_idx(cs_idx),
        .data_abort(data_abort), .prefetch_abort(prefetch_abort)
    );

    // Expected {mem, periph, ext, hit, idx[2:0], dabt, pabt} from the map.
    function automatic logic [8:0] model(input logic [31:0] a, input logic rm,
                                         input logic f);
        int unsigned blk = a >> 20;
        logic m = 0, p = 0, e = 0, h = 0, da = 0, pa = 0;
        logic [2:0] ix = 0;
        if (a >= 32'hFFC0_0000) p = 1;
        else if (a >= 32'h0040_0000) begin
            e = 1;
            if (blk >= 4 && blk <= 11 && (blk == 4 || rm)) begin
                h = 1; ix = 3'(blk - 4);
            end else begin
                da = !f; pa = f;
            end
        end else if (blk == 0 && !rm) begin
            e = 1; h = 1;
        end else m = 1;
        return {m, p, e, h, ix, da, pa};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic rm);
        int unsigned blk = a >> 20;
        if (a >= 32'hFFC0_0000) return "R7";
        if (a < 32'h0040_0000) return "R4";
        if (blk >= 4 && blk <= 11 && (blk == 4 || rm)) return "R5";
        return "R6";
    endfunction

    task automatic check_access(input logic [31:0] a, input logic f, input string tag);
        logic [8:0] got, exp;
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_fetch = f;
        #5;
        got = {sel_mem, sel_periph, sel_ext, cs_hit, cs_idx, data_abort, prefetch_abort};
        exp = model(a, exp_remap, f);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h fetch=%0b actual=%b expected=%b", tag, a, f, got, exp);
        end
    endtask

    task automatic check_reg(input logic [31:0] exp, input string tag);
        checks++;
        if (ctl_rdata !== exp) begin
            fails++;
            $display("FAIL %s ctl_rdata actual=%h expected=%h", tag, ctl_rdata, exp);
        end
    endtask

    task automatic ctl_write(input logic d);
        @(negedge clk);
        bus_req = 1'b0; ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 1'b0;
        #5;
    endtask

    task automatic sweep();
        for (int b = 0; b < 4096; b++) begin
            for (int o = 0; o < 2; o++) begin
                for (int f = 0; f < 2; f++) begin
                    logic [31:0] a = (32'(b) << 20) | (o == 1 ? 32'h000F_FFFF : 32'h0);
                    check_access(a, f[0], tag_of(a, exp_remap));
                end
            end
        end
    endtask

    task automatic boundaries();
        check_access(32'h003F_FFFF, 1'b0, "R9");
        check_access(32'h0040_0000, 1'b0, "R9");
        check_access(32'hFFBF_FFFF, 1'b1, "R9");
        check_access(32'hFFC0_0000, 1'b0, "R9");
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check_reg(32'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R8: idle strobe with an undefined external address
        @(negedge clk);
        bus_req = 1'b0; bus_addr = 32'h2000_0000; bus_fetch = 1'b0;
        #5;
        checks++;
        if ({sel_mem, sel_periph, sel_ext, cs_hit, cs_idx, data_abort, prefetch_abort} !== 9'b0) begin
            fails++;
            $display("FAIL R8 idle outputs actual=%b expected=%b",
                     {sel_mem, sel_periph, sel_ext, cs_hit, cs_idx, data_abort, prefetch_abort}, 9'b0);
        end

        // Boot mapping sweep (R4, R5, R6, R7) and edges (R9)
        sweep();
        boundaries();

        // R3: zero write does nothing in boot mapping
        ctl_write(1'b0);
        check_reg(32'h0, "R3");
        check_access(32'h0000_0000, 1'b1, "R3");

        // R2: remap
        ctl_write(1'b1);
        exp_remap = 1'b1;
        check_reg(32'h1, "R2");

        // R3: zero write after remap keeps it
        ctl_write(1'b0);
        check_reg(32'h1, "R3");

        sweep();
        boundaries();

        // R1/R3: only reset returns to boot mapping
        @(negedge clk);
        bus_req = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_remap = 1'b0;
        #5;
        check_reg(32'h0, "R1");
        check_access(32'h0000_0000, 1'b0, "R4");
        check_access(32'h0050_0000, 1'b0, "R5");

        finish_up();
    end
endmodule